// File: doc/BRIEF.md
# Dead-Band Edge Delay Generator

This block turns one PWM source into a pair of gate-drive signals for a half bridge. It builds two internal versions of the source. In the first, every rising edge is held back by a programmable number of clock cycles. In the second, every falling edge is held back by its own programmable count. The gap this leaves between the two drive signals keeps the upper and lower switches from conducting at the same time.

A two-bit mode field decides, for each output, whether it takes its delayed version or the raw source. A two-bit polarity field then decides which outputs are inverted. This gives same-sense pairs (active high or active low) and complementary pairs. The two delay counts are plain inputs, 0 to 1023 cycles each. They may change at any time, including by one step per period while the block runs, and a new value applies from the next clock cycle.

The only stream in the block is the single-bit source, and it is sampled on every cycle. There is no valid/ready handshake and no back-pressure, because a PWM waveform cannot be paused. All pins are plain control and data pins.

Top module: `dbg_deadband`

## Requirements
- R1: While reset is held and just after it, the rising-edge run counter is zero and the falling-edge run counter is saturated at 1023. With the source low, both delayed versions are therefore low.
- R2: The rising-edge-delayed signal is high only when the source is high and the source was sampled high on at least N consecutive clock edges, where N is `rise_dly_cnt`. It drops in the same cycle as the source.
- R3: The falling-edge-delayed signal is low only when the source is low and the source was sampled low on at least M consecutive clock edges, where M is `fall_dly_cnt`. It rises in the same cycle as the source.
- R4: A delay count of 0 passes the source straight through, with no added cycle.
- R5: A source pulse shorter than the programmed delay never appears on that delayed path.
- R6: Delays up to 1023 work. The run counters saturate and do not wrap, so a level held longer than 1023 cycles keeps the delayed signal asserted.
- R7: `dly_mode` bit 0 set makes `gate_a` take the rising-edge-delayed signal; cleared, `gate_a` takes the source. `dly_mode` bit 1 does the same for `gate_b` with the falling-edge-delayed signal. 2'b11 is full dead-band operation.
- R8: `pol_sel` bit 0 inverts `gate_a` and bit 1 inverts `gate_b`. 00 is active high, 11 is active low, 01 is active-low complementary and 10 is active-high complementary.
- R9: A change to either delay count applies from the next clock cycle, without restarting the run counters.
- R10: With `dly_mode` = 11 and `pol_sel` = 10, `gate_a` and `gate_b` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 1 | PWM source feeding both delay paths |
| rise_dly_cnt | input | DLY_W | Rising-edge delay in clock cycles |
| fall_dly_cnt | input | DLY_W | Falling-edge delay in clock cycles |
| dly_mode | input | 2 | Per-output delay enable (bit 0: A, bit 1: B) |
| pol_sel | input | 2 | Per-output inversion (bit 0: A, bit 1: B) |
| gate_a | output | 1 | Drive output A |
| gate_b | output | 1 | Drive output B |

## Verification
The bench targets these corner cases:

- **Zero delay.** The bench checks that the edge appears in the same cycle. An off-by-one compare would add one cycle here.
- **Pulses one cycle shorter than the delay.** The bench checks these are swallowed. A design that latched the edge instead of measuring the run would let them leak through as narrow glitches.
- **Levels held past 1023 cycles at the maximum delay.** A wrapping counter would drop the output after 1024 cycles.
- **One-step delay changes in the middle of a run.** A design that captured the delay only on an edge would apply the new value one run late.
- **All sixteen mode and polarity pairs, drawn at random.** These catch swapped inversion bits and swapped per-output selects.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned DLY_W = 10;

  typedef enum logic [1:0] {
    POL_HIGH     = 2'b00,
    POL_LOW_CMP  = 2'b01,
    POL_HIGH_CMP = 2'b10,
    POL_LOW      = 2'b11
  } pol_e;
endpackage

// File: rtl/dbg_run_counter.sv
// Counts consecutive clock edges on which src equals LEVEL; saturates at all-ones.
module dbg_run_counter #(
  parameter int unsigned W       = 10,
  parameter bit          LEVEL   = 1'b1,
  parameter bit          RST_MAX = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT     = '1;
  localparam logic [W-1:0] RST_VAL = RST_MAX ? SAT : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= RST_VAL;
    else if (src != LEVEL)   cnt <= '0;
    else if (cnt != SAT)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbg_edge_delay.sv
// One delay path: RISING=1 holds back rising edges, RISING=0 holds back falling edges.
module dbg_edge_delay #(
  parameter int unsigned W      = 10,
  parameter bit          RISING = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src,
  input  logic [W-1:0] thr,
  output logic         dly
);
  logic [W-1:0] run;

  dbg_run_counter #(
    .W       (W),
    .LEVEL   (RISING),
    .RST_MAX (!RISING)
  ) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src),
    .cnt   (run)
  );

  generate
    if (RISING) begin : g_rise
      assign dly = src && (run >= thr);
    end else begin : g_fall
      assign dly = src || (run < thr);
    end
  endgenerate
endmodule

// File: rtl/dbg_out_stage.sv
// Per-output source select and inversion.
module dbg_out_stage (
  input  logic       src,
  input  logic       rise_dly,
  input  logic       fall_dly,
  input  logic [1:0] dly_mode,
  input  logic [1:0] pol_sel,
  output logic       gate_a,
  output logic       gate_b
);
  logic sel_a, sel_b;

  always_comb begin
    sel_a  = dly_mode[0] ? rise_dly : src;
    sel_b  = dly_mode[1] ? fall_dly : src;
    gate_a = sel_a ^ pol_sel[0];
    gate_b = sel_b ^ pol_sel[1];
  end
endmodule

// File: rtl/dbg_deadband.sv
module dbg_deadband #(
  parameter int unsigned DLY_W = dbg_pkg::DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_a,
  input  logic [DLY_W-1:0] rise_dly_cnt,
  input  logic [DLY_W-1:0] fall_dly_cnt,
  input  logic [1:0]       dly_mode,
  input  logic [1:0]       pol_sel,
  output logic             gate_a,
  output logic             gate_b
);
  logic rise_dly, fall_dly;

  dbg_edge_delay #(.W(DLY_W), .RISING(1'b1)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src_a),
    .thr   (rise_dly_cnt),
    .dly   (rise_dly)
  );

  dbg_edge_delay #(.W(DLY_W), .RISING(1'b0)) u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src_a),
    .thr   (fall_dly_cnt),
    .dly   (fall_dly)
  );

  dbg_out_stage u_out (
    .src      (src_a),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .dly_mode (dly_mode),
    .pol_sel  (pol_sel),
    .gate_a   (gate_a),
    .gate_b   (gate_b)
  );
endmodule

// File: rtl/dbg_deadband_chk.sv
module dbg_deadband_chk #(
  parameter int unsigned DLY_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_a,
  input logic [DLY_W-1:0] rise_dly_cnt,
  input logic [DLY_W-1:0] fall_dly_cnt,
  input logic [1:0]       dly_mode,
  input logic [1:0]       pol_sel,
  input logic             gate_a,
  input logic             gate_b,
  input logic             rise_dly,
  input logic             fall_dly
);
  // The first high cycle of the source cannot be delayed-high unless the delay is zero.
  assert_rise_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && src_a && !$past(src_a) && rise_dly_cnt != '0) |-> !rise_dly);

  // The first low cycle of the source keeps the falling-delayed path high.
  assert_fall_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !src_a && $past(src_a) && fall_dly_cnt != '0) |-> fall_dly);

  // A zero rising delay follows the source in the same cycle.
  assert_zero_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_dly_cnt == '0) |-> (rise_dly == src_a));

  // Complementary active-high drive never overlaps.
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_mode == 2'b11 && pol_sel == 2'b10) |-> !(gate_a && gate_b));
endmodule

bind dbg_deadband dbg_deadband_chk #(.DLY_W(DLY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_a        (src_a),
  .rise_dly_cnt (rise_dly_cnt),
  .fall_dly_cnt (fall_dly_cnt),
  .dly_mode     (dly_mode),
  .pol_sel      (pol_sel),
  .gate_a       (gate_a),
  .gate_b       (gate_b),
  .rise_dly     (rise_dly),
  .fall_dly     (fall_dly)
);

// File: tb/sim_dbg_deadband.sv
module sim_dbg_deadband;
  localparam int W   = 10;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         src_a;
  logic [W-1:0] rise_dly_cnt, fall_dly_cnt;
  logic [1:0]   dly_mode, pol_sel;
  logic         gate_a, gate_b;

  always #2 clk = ~clk;

  dbg_deadband #(.DLY_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_a(src_a),
    .rise_dly_cnt(rise_dly_cnt), .fall_dly_cnt(fall_dly_cnt),
    .dly_mode(dly_mode), .pol_sel(pol_sel),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  int n_run = 0, n_fail = 0;
  int m_hi, m_lo;
  bit done = 0;

  // Expected {gate_a, gate_b} from the requirements.
  function automatic logic [1:0] exp_out(logic s, int hi, int lo, int rd, int fd,
                                         logic [1:0] md, logic [1:0] pl);
    logic r, f, a, b;
    r = s && (hi >= rd);        // R2, R4
    f = s || (lo < fd);         // R3, R4
    a = md[0] ? r : s;          // R7
    b = md[1] ? f : s;
    return {a ^ pl[0], b ^ pl[1]}; // R8
  endfunction

  task automatic check(string tag);
    logic [1:0] e;
    e = exp_out(src_a, m_hi, m_lo, rise_dly_cnt, fall_dly_cnt, dly_mode, pol_sel);
    n_run++;
    if ({gate_a, gate_b} !== e) begin
      n_fail++;
      $display("FAIL %s: actual a/b=%b%b expected=%b%b (src=%b hi=%0d lo=%0d rd=%0d fd=%0d mode=%b pol=%b)",
               tag, gate_a, gate_b, e[1], e[0], src_a, m_hi, m_lo,
               rise_dly_cnt, fall_dly_cnt, dly_mode, pol_sel);
    end
  endtask

  // Called at a falling edge: drive, check, let one rising edge pass.
  task automatic step(logic s, string tag);
    src_a = s;
    #1;
    check(tag);
    @(posedge clk);
    if (s) begin m_lo = 0; if (m_hi < MAX) m_hi++; end
    else   begin m_hi = 0; if (m_lo < MAX) m_lo++; end
    @(negedge clk);
  endtask

  task automatic run(logic s, int len, string tag);
    for (int i = 0; i < len; i++) step(s, tag);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_a = 1'b0;
    rise_dly_cnt = 5; fall_dly_cnt = 5; dly_mode = 2'b11; pol_sel = 2'b00;
    m_hi = 0; m_lo = MAX;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1; check("R1 reset");
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    run(1'b0, 3, "R1 after reset");

    // R4: zero delays, full mode, edges same cycle
    rise_dly_cnt = 0; fall_dly_cnt = 0;
    run(1'b1, 3, "R4 zero rise"); run(1'b0, 3, "R4 zero fall");

    // R2/R3/R5: delay 4, pulses of 3 swallowed, then 4 and longer
    rise_dly_cnt = 4; fall_dly_cnt = 4;
    run(1'b1, 3, "R5 short high"); run(1'b0, 8, "R3 low");
    run(1'b1, 8, "R2 high");       run(1'b0, 3, "R5 short low");
    run(1'b1, 6, "R2 high");       run(1'b0, 6, "R3 low");

    // R9: change delay by one mid-run
    run(1'b1, 2, "R9 pre");
    rise_dly_cnt = 3;
    run(1'b1, 3, "R9 shrink");
    rise_dly_cnt = 9; fall_dly_cnt = 2;
    run(1'b1, 2, "R9 grow above run"); run(1'b0, 4, "R9 fall");

    // R6: maximum delay, held past saturation
    rise_dly_cnt = MAX; fall_dly_cnt = MAX;
    run(1'b1, MAX + 60, "R6 max rise"); run(1'b0, MAX + 60, "R6 max fall");
    run(1'b1, MAX - 1, "R5 R6 one short"); run(1'b0, 5, "R6 tail");

    // R7/R8: every mode and polarity pair
    for (int c = 0; c < 16; c++) begin
      dly_mode = c[1:0]; pol_sel = c[3:2];
      rise_dly_cnt = 2; fall_dly_cnt = 3;
      run(1'b1, 4, "R7 R8 R10 high"); run(1'b0, 5, "R7 R8 R10 low");
      run(1'b1, 1, "R5 R7 R8 glitch"); run(1'b0, 2, "R7 R8 low");
    end

    // Random segments with single-step runtime delay changes
    for (int seg = 0; seg < 40; seg++) begin
      dly_mode     = 2'($urandom_range(0, 3));
      pol_sel      = 2'($urandom_range(0, 3));
      rise_dly_cnt = W'($urandom_range(0, 12));
      fall_dly_cnt = W'($urandom_range(0, 12));
      for (int k = 0; k < 60; k++) begin
        if ($urandom_range(0, 7) == 0) begin
          if ($urandom_range(0, 1) == 1) rise_dly_cnt = rise_dly_cnt + 1'b1;
          else if (rise_dly_cnt != 0)    rise_dly_cnt = rise_dly_cnt - 1'b1;
          if ($urandom_range(0, 1) == 1) fall_dly_cnt = fall_dly_cnt + 1'b1;
          else if (fall_dly_cnt != 0)    fall_dly_cnt = fall_dly_cnt - 1'b1;
        end
        run(1'($urandom_range(0, 1)), $urandom_range(1, 15), "R2 R3 R7 R8 R9 random");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule